// File: doc/BRIEF.md
# Rename Credit Limiter

This block sits beside a rename stage that serves several hardware threads. For each thread it works out how many instructions may be renamed in the current cycle without overrunning three downstream structures: the reorder buffer, the issue queue and the load/store queue. Each structure reports its free-entry count from time to time. Those reports are stale by the time they arrive, so the block keeps its own count of instructions that have been renamed but not yet dispatched. It subtracts the part of that count still outstanding from each stored report.

Every cycle, and for every thread, the block takes the smallest estimated free space and compares it with the number of instructions waiting. From that it gives a rename limit, a block request towards the earlier stages, and a code that says which structure is the tightest. The rename stage feeds back how many instructions it actually renamed, and the dispatch stage feeds back how many it sent on. Together these keep the in-flight count current. Threads are fully independent.

Top module: `rn_credit_limiter`

## Requirements
- R1: After reset, every stored free count and every thread's in-flight count is 0 and every latched empty flag is 1. Each thread therefore requests a block, gives a limit of 0 and reports the reorder buffer (code 0) as the limiting structure.
- R2: A reported free count is stored only in a cycle where its own valid bit is 1. It affects the outputs from the next cycle on. A report whose valid bit is 0 leaves the stored count unchanged.
- R3: The free-space estimates for the reorder buffer and the issue queue are each the stored count minus (in-flight count minus the thread's total dispatched count in this cycle).
- R4: The load/store queue estimate is its stored count minus (in-flight count minus the count dispatched to the load/store queue in this cycle). The total dispatched count plays no part in it.
- R5: The limiting-structure code is 0 for the reorder buffer, 1 for the issue queue and 2 for the load/store queue. The reorder buffer is the default. The issue queue is chosen only if its estimate is strictly smaller than the reorder buffer's. The load/store queue is chosen only if its estimate is strictly smaller than the one chosen so far. On a tie the earlier structure wins.
- R6: When the smallest estimate is 0 or negative, the limit is 0 and a block is requested, whatever the number of available instructions.
- R7: When the smallest estimate is positive but below the number of available instructions, the limit equals that estimate and a block is still requested.
- R8: When the smallest estimate is at least the number of available instructions, the limit equals the available count and no block is requested.
- R9: The in-flight count changes at each clock edge by adding the number renamed and subtracting the total dispatched count. It never goes below 0.
- R10: The reorder-buffer empty flag is latched together with the reorder-buffer count, and only when that report is valid. It is shown on a per-thread output from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rob_rpt_vld_i | input | NUM_THR | Reorder-buffer report valid, one bit per thread |
| rob_rpt_cnt_i | input | NUM_THR*CNT_W | Reorder-buffer free count per thread |
| rob_rpt_empty_i | input | NUM_THR | Reorder-buffer empty flag per thread |
| iq_rpt_vld_i | input | NUM_THR | Issue-queue report valid per thread |
| iq_rpt_cnt_i | input | NUM_THR*CNT_W | Issue-queue free count per thread |
| lsq_rpt_vld_i | input | NUM_THR | Load/store-queue report valid per thread |
| lsq_rpt_cnt_i | input | NUM_THR*CNT_W | Load/store-queue free count per thread |
| disp_all_i | input | NUM_THR*LANE_W | Instructions dispatched this cycle, per thread |
| disp_mem_i | input | NUM_THR*LANE_W | Of those, dispatched to the load/store queue |
| avail_i | input | NUM_THR*LANE_W | Instructions waiting to be renamed |
| renamed_i | input | NUM_THR*LANE_W | Instructions renamed this cycle (at most the limit) |
| limit_o | output | NUM_THR*LANE_W | Rename limit for this cycle |
| block_o | output | NUM_THR | Block request towards earlier stages |
| src_o | output | NUM_THR*2 | Limiting-structure code (0 ROB, 1 IQ, 2 LSQ) |
| rob_empty_o | output | NUM_THR | Latched reorder-buffer empty flag |

## Verification
The main function is driven with reports that make each structure the unique minimum in turn, so a wrong selection or a wrong subtraction shows up as a different limit or code. Reports that tie (reorder buffer equal to issue queue, and issue queue equal to load/store queue) separate strict from non-strict comparison. Dispatch patterns where the load/store count differs from the total separate the two dispatch paths. Stored counts below the in-flight count separate the non-positive, clamped and unclamped limit cases. A run of random reports, dispatches and renames on both threads then checks that the in-flight bookkeeping and the per-thread independence hold over many cycles.

// File: rtl/rncl_pkg.sv
`timescale 1ns/1ps
// Shared types for the rename credit limiter.
package rncl_pkg;
    // Limiting structure code; encoding is visible at the top ports.
    typedef enum logic [1:0] {
        SRC_ROB = 2'd0,
        SRC_IQ  = 2'd1,
        SRC_LSQ = 2'd2
    } lim_src_e;
endpackage

// File: rtl/rncl_credit_store.sv
`timescale 1ns/1ps
// Holds one structure's last reported free count for one thread.
// Assumes: a report is only trusted when its valid bit is set.
module rncl_credit_store #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rpt_vld,
    input  logic [CNT_W-1:0] rpt_cnt,
    output logic [CNT_W-1:0] cnt_q
);
    // Capture a valid report; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (rpt_vld)
            cnt_q <= rpt_cnt;
    end
endmodule

// File: rtl/rncl_inflight.sv
`timescale 1ns/1ps
// Counts instructions renamed but not yet dispatched for one thread.
// Assumes: dispatch never exceeds the count; the floor at 0 is a guard.
module rncl_inflight #(
    parameter int LANE_W = 4,
    parameter int IFL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] renamed,
    input  logic [LANE_W-1:0] disp_all,
    output logic [IFL_W-1:0]  cnt_q
);
    localparam int SUM_W = IFL_W + 1;

    logic [SUM_W-1:0] grown;
    logic [SUM_W-1:0] drop;
    logic [IFL_W-1:0] cnt_d;

    // Add renamed, remove dispatched, floor at zero.
    always_comb begin
        grown = {1'b0, cnt_q} + {{(SUM_W-LANE_W){1'b0}}, renamed};
        drop  = {{(SUM_W-LANE_W){1'b0}}, disp_all};
        if (grown < drop)
            cnt_d = '0;
        else
            cnt_d = IFL_W'(grown - drop);
    end

    // Register the updated in-flight count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rncl_pick.sv
`timescale 1ns/1ps
// Estimates free space of the three structures, picks the tightest
// and turns it into a rename limit and block request. Purely combinational.
// Assumes: LANE_W < CNT_W + 2 so every lane count fits the signed width.
module rncl_pick
    import rncl_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int LANE_W = 4,
    parameter int IFL_W  = 7
) (
    input  logic [CNT_W-1:0]  rob_cnt,
    input  logic [CNT_W-1:0]  iq_cnt,
    input  logic [CNT_W-1:0]  lsq_cnt,
    input  logic [IFL_W-1:0]  inflight,
    input  logic [LANE_W-1:0] disp_all,
    input  logic [LANE_W-1:0] disp_mem,
    input  logic [LANE_W-1:0] avail,
    output logic [LANE_W-1:0] limit,
    output logic              block,
    output lim_src_e          src
);
    localparam int FREE_W = (IFL_W > CNT_W ? IFL_W : CNT_W) + 2;

    logic signed [FREE_W-1:0] inflt_s, dall_s, dmem_s, avail_s;
    logic signed [FREE_W-1:0] rob_free, iq_free, lsq_free, min_free;

    // Extend every count to one signed width.
    always_comb begin
        inflt_s = $signed({{(FREE_W-IFL_W){1'b0}}, inflight});
        dall_s  = $signed({{(FREE_W-LANE_W){1'b0}}, disp_all});
        dmem_s  = $signed({{(FREE_W-LANE_W){1'b0}}, disp_mem});
        avail_s = $signed({{(FREE_W-LANE_W){1'b0}}, avail});
    end

    // Free space estimates; the load/store queue uses its own dispatch count.
    always_comb begin
        rob_free = $signed({{(FREE_W-CNT_W){1'b0}}, rob_cnt}) - (inflt_s - dall_s);
        iq_free  = $signed({{(FREE_W-CNT_W){1'b0}}, iq_cnt})  - (inflt_s - dall_s);
        lsq_free = $signed({{(FREE_W-CNT_W){1'b0}}, lsq_cnt}) - (inflt_s - dmem_s);
    end

    // Minimum with strict-less replacement, reorder buffer by default.
    always_comb begin
        min_free = rob_free;
        src      = SRC_ROB;
        if (iq_free < min_free) begin
            min_free = iq_free;
            src      = SRC_IQ;
        end
        if (lsq_free < min_free) begin
            min_free = lsq_free;
            src      = SRC_LSQ;
        end
    end

    // Clamp the available count against the tightest structure.
    always_comb begin
        if (min_free <= 0) begin
            limit = '0;
            block = 1'b1;
        end else if (min_free < avail_s) begin
            limit = min_free[LANE_W-1:0];
            block = 1'b1;
        end else begin
            limit = avail;
            block = 1'b0;
        end
    end
endmodule

// File: rtl/rncl_thread.sv
`timescale 1ns/1ps
// All per-thread state and logic: three report stores, the empty flag,
// the in-flight counter and the limit picker.
module rncl_thread
    import rncl_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int LANE_W = 4,
    parameter int IFL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rob_vld,
    input  logic [CNT_W-1:0]  rob_cnt,
    input  logic              rob_empty,
    input  logic              iq_vld,
    input  logic [CNT_W-1:0]  iq_cnt,
    input  logic              lsq_vld,
    input  logic [CNT_W-1:0]  lsq_cnt,
    input  logic [LANE_W-1:0] disp_all,
    input  logic [LANE_W-1:0] disp_mem,
    input  logic [LANE_W-1:0] avail,
    input  logic [LANE_W-1:0] renamed,
    output logic [LANE_W-1:0] limit,
    output logic              block,
    output logic [1:0]        src,
    output logic              empty_q,
    output logic [IFL_W-1:0]  inflight
);
    logic [CNT_W-1:0] rob_q, iq_q, lsq_q;
    lim_src_e         src_e;

    rncl_credit_store #(.CNT_W(CNT_W)) u_rob (
        .clk(clk), .rst_n(rst_n), .rpt_vld(rob_vld), .rpt_cnt(rob_cnt), .cnt_q(rob_q));
    rncl_credit_store #(.CNT_W(CNT_W)) u_iq (
        .clk(clk), .rst_n(rst_n), .rpt_vld(iq_vld), .rpt_cnt(iq_cnt), .cnt_q(iq_q));
    rncl_credit_store #(.CNT_W(CNT_W)) u_lsq (
        .clk(clk), .rst_n(rst_n), .rpt_vld(lsq_vld), .rpt_cnt(lsq_cnt), .cnt_q(lsq_q));

    // Latch the empty flag alongside a valid reorder-buffer report.
    always_ff @(posedge clk) begin
        if (!rst_n)
            empty_q <= 1'b1;
        else if (rob_vld)
            empty_q <= rob_empty;
    end

    rncl_inflight #(.LANE_W(LANE_W), .IFL_W(IFL_W)) u_ifl (
        .clk(clk), .rst_n(rst_n), .renamed(renamed), .disp_all(disp_all),
        .cnt_q(inflight));

    rncl_pick #(.CNT_W(CNT_W), .LANE_W(LANE_W), .IFL_W(IFL_W)) u_pick (
        .rob_cnt(rob_q), .iq_cnt(iq_q), .lsq_cnt(lsq_q), .inflight(inflight),
        .disp_all(disp_all), .disp_mem(disp_mem), .avail(avail),
        .limit(limit), .block(block), .src(src_e));

    // Present the code as plain bits.
    always_comb src = src_e;
endmodule

// File: rtl/rn_credit_limiter.sv
`timescale 1ns/1ps
// Rename credit limiter, top level. One independent slice per thread;
// per-thread fields are packed side by side, thread 0 in the low bits.
// Assumes: renamed <= limit, disp_mem <= disp_all <= in-flight count.
module rn_credit_limiter #(
    parameter int NUM_THR = 2,
    parameter int CNT_W   = 6,
    parameter int LANE_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_THR-1:0]        rob_rpt_vld_i,
    input  logic [NUM_THR*CNT_W-1:0]  rob_rpt_cnt_i,
    input  logic [NUM_THR-1:0]        rob_rpt_empty_i,
    input  logic [NUM_THR-1:0]        iq_rpt_vld_i,
    input  logic [NUM_THR*CNT_W-1:0]  iq_rpt_cnt_i,
    input  logic [NUM_THR-1:0]        lsq_rpt_vld_i,
    input  logic [NUM_THR*CNT_W-1:0]  lsq_rpt_cnt_i,
    input  logic [NUM_THR*LANE_W-1:0] disp_all_i,
    input  logic [NUM_THR*LANE_W-1:0] disp_mem_i,
    input  logic [NUM_THR*LANE_W-1:0] avail_i,
    input  logic [NUM_THR*LANE_W-1:0] renamed_i,
    output logic [NUM_THR*LANE_W-1:0] limit_o,
    output logic [NUM_THR-1:0]        block_o,
    output logic [NUM_THR*2-1:0]      src_o,
    output logic [NUM_THR-1:0]        rob_empty_o
);
    localparam int IFL_W = CNT_W + 1;

    logic [NUM_THR*IFL_W-1:0] inflight_q;

    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        rncl_thread #(.CNT_W(CNT_W), .LANE_W(LANE_W), .IFL_W(IFL_W)) u_thr (
            .clk      (clk),
            .rst_n    (rst_n),
            .rob_vld  (rob_rpt_vld_i[t]),
            .rob_cnt  (rob_rpt_cnt_i[t*CNT_W +: CNT_W]),
            .rob_empty(rob_rpt_empty_i[t]),
            .iq_vld   (iq_rpt_vld_i[t]),
            .iq_cnt   (iq_rpt_cnt_i[t*CNT_W +: CNT_W]),
            .lsq_vld  (lsq_rpt_vld_i[t]),
            .lsq_cnt  (lsq_rpt_cnt_i[t*CNT_W +: CNT_W]),
            .disp_all (disp_all_i[t*LANE_W +: LANE_W]),
            .disp_mem (disp_mem_i[t*LANE_W +: LANE_W]),
            .avail    (avail_i[t*LANE_W +: LANE_W]),
            .renamed  (renamed_i[t*LANE_W +: LANE_W]),
            .limit    (limit_o[t*LANE_W +: LANE_W]),
            .block    (block_o[t]),
            .src      (src_o[t*2 +: 2]),
            .empty_q  (rob_empty_o[t]),
            .inflight (inflight_q[t*IFL_W +: IFL_W])
        );
    end
endmodule

// File: rtl/rncl_credit_chk.sv
`timescale 1ns/1ps
// Property checker for the rename credit limiter, bound to the top.
module rncl_credit_chk #(
    parameter int NUM_THR = 2,
    parameter int CNT_W   = 6,
    parameter int LANE_W  = 4,
    parameter int IFL_W   = 7
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_THR-1:0]        rob_rpt_vld_i,
    input logic [NUM_THR*LANE_W-1:0] disp_all_i,
    input logic [NUM_THR*LANE_W-1:0] avail_i,
    input logic [NUM_THR*LANE_W-1:0] renamed_i,
    input logic [NUM_THR*LANE_W-1:0] limit_o,
    input logic [NUM_THR-1:0]        block_o,
    input logic [NUM_THR*2-1:0]      src_o,
    input logic [NUM_THR-1:0]        rob_empty_o,
    input logic [NUM_THR*IFL_W-1:0]  inflight_q
);
    // R1: the cycle after a reset edge every empty flag reads 1.
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (rob_empty_o == '1));

    for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
        logic [LANE_W-1:0] lim, av, rn, ds;
        logic [IFL_W-1:0]  ifl;
        always_comb begin
            lim = limit_o[t*LANE_W +: LANE_W];
            av  = avail_i[t*LANE_W +: LANE_W];
            rn  = renamed_i[t*LANE_W +: LANE_W];
            ds  = disp_all_i[t*LANE_W +: LANE_W];
            ifl = inflight_q[t*IFL_W +: IFL_W];
        end

        p_limit_le_avail_r8: assert property (@(posedge clk) disable iff (!rst_n)
            lim <= av);
        p_open_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !block_o[t] |-> (lim == av));
        p_zero_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (lim == '0 && av != '0) |-> block_o[t]);
        p_src_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
            src_o[t*2 +: 2] != 2'd3);
        p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
            {{(IFL_W > LANE_W ? IFL_W-LANE_W : 0){1'b0}}, ds} <= ifl);
        p_ren_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rn <= lim);
        p_empty_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !rob_rpt_vld_i[t] |=> $stable(rob_empty_o[t]));
    end
endmodule

bind rn_credit_limiter rncl_credit_chk #(
    .NUM_THR(NUM_THR), .CNT_W(CNT_W), .LANE_W(LANE_W), .IFL_W(CNT_W + 1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rob_rpt_vld_i(rob_rpt_vld_i),
    .disp_all_i(disp_all_i), .avail_i(avail_i), .renamed_i(renamed_i),
    .limit_o(limit_o), .block_o(block_o), .src_o(src_o),
    .rob_empty_o(rob_empty_o), .inflight_q(inflight_q)
);

// File: tb/tb_rn_credit_limiter.sv
`timescale 1ns/1ps
module tb_rn_credit_limiter;
    localparam int NT = 2;
    localparam int CW = 6;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NT-1:0]    rob_vld, rob_emp, iq_vld, lsq_vld;
    logic [NT*CW-1:0] rob_cnt, iq_cnt, lsq_cnt;
    logic [NT*LW-1:0] dall, dmem, avail, ren;
    logic [NT*LW-1:0] limit_o;
    logic [NT-1:0]    block_o, empty_o;
    logic [NT*2-1:0]  src_o;

    rn_credit_limiter #(.NUM_THR(NT), .CNT_W(CW), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n),
        .rob_rpt_vld_i(rob_vld), .rob_rpt_cnt_i(rob_cnt), .rob_rpt_empty_i(rob_emp),
        .iq_rpt_vld_i(iq_vld), .iq_rpt_cnt_i(iq_cnt),
        .lsq_rpt_vld_i(lsq_vld), .lsq_rpt_cnt_i(lsq_cnt),
        .disp_all_i(dall), .disp_mem_i(dmem), .avail_i(avail), .renamed_i(ren),
        .limit_o(limit_o), .block_o(block_o), .src_o(src_o), .rob_empty_o(empty_o));

    // Planned stimulus per thread (set by the test, applied by the driver).
    int p_rob[NT], p_iq[NT], p_lsq[NT], p_dall[NT], p_dmem[NT], p_av[NT], p_ren[NT];
    bit p_rv[NT], p_iv[NT], p_lv[NT], p_re[NT];
    // Reference state derived from the requirements.
    int m_rob[NT], m_iq[NT], m_lsq[NT], m_ifl[NT];
    bit m_emp[NT];

    typedef struct {
        string tag;
        int    thr;
        int    lim;
        bit    blk;
        int    src;
        bit    emp;
    } exp_t;
    exp_t sb[$];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    task automatic clear_plan();
        for (int t = 0; t < NT; t++) begin
            p_rv[t] = 0; p_iv[t] = 0; p_lv[t] = 0;
            p_dall[t] = 0; p_dmem[t] = 0; p_ren[t] = 0;
        end
    endtask

    // Driver: apply one cycle of stimulus, push expectations, advance model.
    task automatic drive(input string tag);
        int fr, fi, fl, mn, src, lim, rn;
        bit blk;
        @(negedge clk);
        #1;
        for (int t = 0; t < NT; t++) begin
            fr = m_rob[t] - (m_ifl[t] - p_dall[t]);
            fi = m_iq[t]  - (m_ifl[t] - p_dall[t]);
            fl = m_lsq[t] - (m_ifl[t] - p_dmem[t]);
            mn = fr; src = 0;
            if (fi < mn) begin mn = fi; src = 1; end
            if (fl < mn) begin mn = fl; src = 2; end
            if (mn <= 0)              begin lim = 0;       blk = 1; end
            else if (mn < p_av[t])    begin lim = mn;      blk = 1; end
            else                      begin lim = p_av[t]; blk = 0; end
            rn = (p_ren[t] < lim) ? p_ren[t] : lim;
            rob_vld[t] = p_rv[t]; rob_emp[t] = p_re[t];
            iq_vld[t] = p_iv[t]; lsq_vld[t] = p_lv[t];
            rob_cnt[t*CW +: CW] = CW'(p_rob[t]);
            iq_cnt[t*CW +: CW]  = CW'(p_iq[t]);
            lsq_cnt[t*CW +: CW] = CW'(p_lsq[t]);
            dall[t*LW +: LW]  = LW'(p_dall[t]);
            dmem[t*LW +: LW]  = LW'(p_dmem[t]);
            avail[t*LW +: LW] = LW'(p_av[t]);
            ren[t*LW +: LW]   = LW'(rn);
            sb.push_back('{tag, t, lim, blk, src, m_emp[t]});
            // State after the coming edge.
            if (p_rv[t]) begin m_rob[t] = p_rob[t]; m_emp[t] = p_re[t]; end
            if (p_iv[t]) m_iq[t] = p_iq[t];
            if (p_lv[t]) m_lsq[t] = p_lsq[t];
            m_ifl[t] = m_ifl[t] + rn - p_dall[t];
        end
        clear_plan();
    endtask

    // Monitor: compare outputs late in the low phase, before the edge.
    initial begin
        forever begin
            @(negedge clk);
            #8;
            while (sb.size() > 0) begin
                exp_t e;
                int t;
                e = sb.pop_front();
                t = e.thr;
                checks++;
                if (int'(limit_o[t*LW +: LW]) != e.lim || block_o[t] != e.blk ||
                    int'(src_o[t*2 +: 2]) != e.src || empty_o[t] != e.emp) begin
                    errors++;
                    $display("FAIL %s thr%0d: got lim=%0d blk=%0d src=%0d emp=%0d exp lim=%0d blk=%0d src=%0d emp=%0d",
                             e.tag, t, limit_o[t*LW +: LW], block_o[t], src_o[t*2 +: 2],
                             empty_o[t], e.lim, e.blk, e.src, e.emp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rob_vld = '0; rob_emp = '0; iq_vld = '0; lsq_vld = '0;
        rob_cnt = '0; iq_cnt = '0; lsq_cnt = '0;
        dall = '0; dmem = '0; avail = '0; ren = '0;
        for (int t = 0; t < NT; t++) begin
            m_rob[t] = 0; m_iq[t] = 0; m_lsq[t] = 0; m_ifl[t] = 0; m_emp[t] = 1;
            p_rob[t] = 0; p_iq[t] = 0; p_lsq[t] = 0; p_re[t] = 0; p_av[t] = 3;
        end
        clear_plan();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, both threads blocked with limit 0, ROB code, empty 1.
        drive("R1");

        // R2: invalid reports with large counts must not be stored.
        for (int t = 0; t < NT; t++) begin
            p_rob[t] = 40; p_iq[t] = 40; p_lsq[t] = 40; p_re[t] = 0;
        end
        drive("R2");
        // Valid reports now; this cycle still shows the old (zero) counts.
        p_rv[0] = 1; p_rob[0] = 10; p_iv[0] = 1; p_iq[0] = 8; p_lv[0] = 1; p_lsq[0] = 12; p_re[0] = 0;
        p_rv[1] = 1; p_rob[1] = 5;  p_iv[1] = 1; p_iq[1] = 5; p_lv[1] = 1; p_lsq[1] = 9;  p_re[1] = 1;
        drive("R2");

        // R5/R8/R10: thread 0 IQ tightest, thread 1 ROB/IQ tie keeps ROB.
        p_av[0] = 4; p_ren[0] = 4; p_ren[1] = 3;
        drive("R5");

        // R7/R3: in-flight reduces ROB/IQ space; clamp below available.
        p_av[0] = 6; p_dall[1] = 2;
        p_lv[0] = 1; p_lsq[0] = 6;
        drive("R7");

        // R4: LSQ uses its own dispatch count (3 total, 1 to LSQ).
        p_dall[0] = 3; p_dmem[0] = 1;
        p_rv[0] = 1; p_rob[0] = 1; p_re[0] = 1;
        drive("R4");

        // R6/R10: stored ROB count 1 with in-flight 1 gives zero space.
        drive("R6");

        // R9: dispatching the last in-flight instruction restores space.
        p_dall[0] = 1; p_dmem[0] = 1;
        p_rv[0] = 1; p_rob[0] = 10; p_re[0] = 0;
        p_iv[0] = 1; p_iq[0] = 4; p_lv[0] = 1; p_lsq[0] = 4;
        drive("R9");

        // R5: IQ equals LSQ, both below ROB, IQ wins the tie.
        p_av[0] = 3;
        drive("R5");

        // R8: plenty of space, no block.
        p_av[0] = 2; p_av[1] = 2;
        drive("R8");

        // R3: random traffic on both threads.
        for (int i = 0; i < 200; i++) begin
            for (int t = 0; t < NT; t++) begin
                p_rv[t] = ($urandom_range(0, 3) == 0);
                p_iv[t] = ($urandom_range(0, 3) == 0);
                p_lv[t] = ($urandom_range(0, 3) == 0);
                p_re[t] = $urandom_range(0, 1);
                p_rob[t] = $urandom_range(0, 40);
                p_iq[t]  = $urandom_range(0, 40);
                p_lsq[t] = $urandom_range(0, 40);
                p_dall[t] = (m_ifl[t] < 6) ? $urandom_range(0, m_ifl[t]) : $urandom_range(0, 6);
                p_dmem[t] = $urandom_range(0, p_dall[t]);
                p_av[t]  = $urandom_range(0, 8);
                p_ren[t] = $urandom_range(0, 8);
            end
            drive("R3");
        end

        @(negedge clk);
        #9;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule